// File: doc/BRIEF.md
# Polled Serial Port on a 16-bit Register Bus

This block is a full-duplex asynchronous serial port that a small 16-bit processor drives through two register addresses. They sit at the very top of a 4K-word address space. The processor writes a character to either address to send it. It reads the upper address to collect the last received character, and the lower address to fetch a three-flag status word. There are no queues. Software checks the transmit-idle flag before each write and the receive-valid flag before each read.

The line format is one start bit, eight data bits sent least significant first, and one stop bit. The line idles high. The transmitter and receiver share one timing scheme: an oversampling tick runs at sixteen times the line rate and is derived from the system clock. Each direction has its own copy of the tick counter, so the two directions run independently.

The register bus is a plain strobe interface with no handshake. There is no back-pressure signal. A write that arrives while a frame is still being sent is dropped. Flow control is left entirely to the software, which polls the transmit-idle flag.

Top module: `mmio_serial_port`

## Requirements
- R1: A write strobe to address 0xFFF or 0xFFE while the transmitter is idle sends bus_wdata[7:0] as one frame. ser_txd goes low in the cycle after the write edge and holds each bit for 16 × OS_DIV cycles: start (0), data bits 0 to 7, then stop (1). At every other time ser_txd is high.
- R2: A write strobe to either address while a frame is still being sent has no effect on the frame in progress or on any later output.
- R3: A write strobe to any other address starts nothing.
- R4: A read of 0xFFE returns status with bit 2 = transmit idle, bit 1 = receiver idle and bit 0 = receive valid, and bits 15..3 zero. Transmit idle is 0 from the accepting write edge until the stop bit has been fully sent.
- R5: A read of 0xFFF returns the last good received byte in bits 7..0, with bits 15..8 zero.
- R6: Receive valid sets when a frame ends with its stop bit sampled high. A newer good frame overwrites the byte. A read of 0xFFF clears receive valid, unless a new frame completes in the same cycle.
- R7: A frame whose stop bit samples low is discarded: receive valid and the received byte keep their values. The receiver then waits for the line to return high before it looks for the next start bit.
- R8: A low pulse shorter than half a bit time is rejected at the mid-point of the start bit. The receiver returns to idle without setting receive valid.
- R9: A frame can be sent and another received at the same time, without either one disturbing the other.
- R10: bus_rdata is zero whenever bus_rd is low or the read address is neither 0xFFF nor 0xFFE.
- R11: OS_DIV = round(CLK_HZ / (16 × BAUD_RATE)). With the defaults (10 MHz, 19200 baud) this gives 33, so one bit lasts 528 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Word address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data; bits 7..0 are the character to send |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 16 | Read data, combinational from the address |
| ser_txd | output | 1 | Serial transmit line, idles high |
| ser_rxd | input | 1 | Serial receive line, idles high |

## Verification
The hardest states to reach from the pins are the receiver's two abort paths. The first is a start bit that vanishes before its mid-point. The second is a stop bit that samples low, after which the line is still low when the receiver gives up on the frame. The bench drives the receive line directly, bit by bit. It sends a quarter-bit glitch, then a full frame with a forced-low stop bit. It then confirms through the status and data registers that neither event changed the stored byte or the valid flag. The same-cycle race between a transmit write and the end of a frame is covered by a cycle-level model of the transmit line, compared on every clock.

// File: rtl/mmio_serial_pkg.sv
package mmio_serial_pkg;
  localparam int OVERSAMPLE = 16;
  localparam int FRAME_BITS = 10;

  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_BREAK = 2'd2
  } rx_state_e;

  function automatic int os_divisor(input int clk_hz, input int baud);
    return (clk_hz + baud * (OVERSAMPLE / 2)) / (baud * OVERSAMPLE);
  endfunction
endpackage

// File: rtl/serial_tick_gen.sv
module serial_tick_gen #(
  parameter int DIV = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr_i || cnt == CW'(DIV - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick_o = !clr_i && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import mmio_serial_pkg::*;
#(
  parameter int OS_DIV = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       txd_o,
  output logic       idle_o
);
  localparam int OSW = $clog2(OVERSAMPLE);

  logic                  busy;
  logic [FRAME_BITS-1:0] sh;
  logic [OSW-1:0]        os_cnt;
  logic [3:0]            bit_cnt;
  logic                  tick;

  serial_tick_gen #(.DIV(OS_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!busy),
    .tick_o (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh      <= '1;
      os_cnt  <= '0;
      bit_cnt <= '0;
    end else if (!busy) begin
      if (start_i) begin
        busy    <= 1'b1;
        sh      <= {1'b1, data_i, 1'b0};
        os_cnt  <= '0;
        bit_cnt <= '0;
      end
    end else if (tick) begin
      os_cnt <= os_cnt + 1'b1;
      if (os_cnt == OSW'(OVERSAMPLE - 1)) begin
        sh      <= {1'b1, sh[FRAME_BITS-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 4'(FRAME_BITS - 1)) busy <= 1'b0;
      end
    end
  end

  assign txd_o  = busy ? sh[0] : 1'b1;
  assign idle_o = !busy;

  // R1
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd_o);

  // R1
  tx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd_o));
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import mmio_serial_pkg::*;
#(
  parameter int OS_DIV = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_i,
  output logic [7:0] data_o,
  output logic       done_o,
  output logic       idle_o
);
  localparam int OSW = $clog2(OVERSAMPLE);
  localparam logic [OSW-1:0] MID = OSW'(OVERSAMPLE / 2 - 1);

  rx_state_e      state;
  logic [1:0]     sync;
  logic           rxs;
  logic [OSW-1:0] os_cnt;
  logic [3:0]     bit_idx;
  logic [7:0]     sh;
  logic           tick;

  assign rxs = sync[1];

  serial_tick_gen #(.DIV(OS_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (state != RX_SHIFT),
    .tick_o (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
    end else begin
      sync <= {sync[0], rxd_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_HUNT;
      os_cnt  <= '0;
      bit_idx <= '0;
      sh      <= '0;
      data_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        RX_HUNT: begin
          os_cnt  <= '0;
          bit_idx <= '0;
          if (!rxs) state <= RX_SHIFT;
        end
        RX_SHIFT: begin
          if (tick) begin
            os_cnt <= os_cnt + 1'b1;
            if (os_cnt == MID) begin
              if (bit_idx == 4'd0) begin
                if (rxs) state <= RX_HUNT;
              end else if (bit_idx == 4'(FRAME_BITS - 1)) begin
                if (rxs) begin
                  data_o <= sh;
                  done_o <= 1'b1;
                  state  <= RX_HUNT;
                end else begin
                  state <= RX_BREAK;
                end
              end else begin
                sh <= {rxs, sh[7:1]};
              end
            end
            if (os_cnt == OSW'(OVERSAMPLE - 1)) bit_idx <= bit_idx + 1'b1;
          end
        end
        RX_BREAK: begin
          if (rxs) state <= RX_HUNT;
        end
        default: state <= RX_HUNT;
      endcase
    end
  end

  assign idle_o = (state == RX_HUNT);

  // R6
  rx_done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rxs) && $past(state == RX_SHIFT)));

  // R8
  rx_false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_SHIFT && tick && os_cnt == MID && bit_idx == 4'd0 && rxs)
      |=> (state == RX_HUNT && !done_o));

  // R7
  rx_break_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_BREAK && !rxs) |=> (state == RX_BREAK));
endmodule

// File: rtl/mmio_serial_port.sv
module mmio_serial_port
  import mmio_serial_pkg::*;
#(
  parameter int CLK_HZ    = 10_000_000,
  parameter int BAUD_RATE = 19_200,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ser_txd,
  input  logic              ser_rxd
);
  localparam int OS_DIV = os_divisor(CLK_HZ, BAUD_RATE);
  localparam logic [ADDR_W-1:0] DATA_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] STAT_ADDR = DATA_ADDR - 1'b1;

  logic       hit_data, hit_stat;
  logic       wr_hit, rd_data;
  logic       tx_idle, rx_idle, rx_done, rx_valid;
  logic [7:0] rx_byte;
  logic       unused_hi;

  assign hit_data  = (bus_addr == DATA_ADDR);
  assign hit_stat  = (bus_addr == STAT_ADDR);
  assign wr_hit    = bus_wr && (hit_data || hit_stat);
  assign rd_data   = bus_rd && hit_data;
  assign unused_hi = ^bus_wdata[DATA_W-1:8];

  serial_tx #(.OS_DIV(OS_DIV)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (wr_hit),
    .data_i  (bus_wdata[7:0]),
    .txd_o   (ser_txd),
    .idle_o  (tx_idle)
  );

  serial_rx #(.OS_DIV(OS_DIV)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxd_i  (ser_rxd),
    .data_o (rx_byte),
    .done_o (rx_done),
    .idle_o (rx_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
    end else if (rx_done) begin
      rx_valid <= 1'b1;
    end else if (rd_data) begin
      rx_valid <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_data)      bus_rdata[7:0] = rx_byte;
      else if (hit_stat) bus_rdata[2:0] = {tx_idle, rx_idle, rx_valid};
    end
  end

  // R6
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_done) |=> !rx_valid);

  // R6
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_valid);

  // R4
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> ser_txd);
endmodule

// File: tb/mmio_serial_port_bench.sv
module mmio_serial_port_bench;
  localparam int CLK_HZ = 10_000_000;
  localparam int BAUD   = 19_200;
  localparam int OSD    = (CLK_HZ + BAUD * 8) / (BAUD * 16);
  localparam int BITC   = 16 * OSD;
  localparam logic [11:0] A_DATA = 12'hFFF;
  localparam logic [11:0] A_STAT = 12'hFFE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        ser_txd;
  logic        ser_rxd = 1'b1;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mmio_serial_port u_mmio_serial_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ser_txd   (ser_txd),
    .ser_rxd   (ser_rxd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // transmit-line reference model
  bit       m_busy = 0;
  int       m_cnt = 0;
  bit [9:0] m_frame = '1;

  always @(posedge clk) begin
    bit was;
    if (!rst_n) begin
      m_busy = 0;
      m_cnt  = 0;
    end else begin
      was = m_busy;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 10 * BITC) m_busy = 0;
      end
      if (bus_wr && (bus_addr == A_DATA || bus_addr == A_STAT) && !was) begin
        m_busy  = 1;
        m_cnt   = 0;
        m_frame = {1'b1, bus_wdata[7:0], 1'b0};
      end
    end
  end

  always @(negedge clk) begin
    logic exp_txd;
    if (rst_n && !finished) begin
      exp_txd = m_busy ? m_frame[m_cnt / BITC] : 1'b1;
      check(ser_txd === exp_txd, "R1/R2", "txd", int'(ser_txd), int'(exp_txd));
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(input logic [11:0] a, input logic [15:0] exp, input string req);
    logic [15:0] d;
    bus_read(a, d);
    check(d === exp, req, (a == A_STAT) ? "status" : "read", int'(d), int'(exp));
  endtask

  task automatic poll_tx_idle();
    logic [15:0] d;
    for (int i = 0; i < 12 * BITC; i++) begin
      bus_read(A_STAT, d);
      if (d[2]) return;
    end
    check(1'b0, "R4", "tx idle never returned", 0, 1);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      ser_rxd = f[i];
      repeat (BITC) @(negedge clk);
    end
    ser_rxd = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R4 reset state: tx idle, rx idle, no valid
    expect_reg(A_STAT, 16'h0006, "R4");
    // R10 unmapped read and idle read path
    expect_reg(12'h000, 16'h0000, "R10");
    @(negedge clk);
    check(bus_rdata === 16'h0, "R10", "rdata with rd low", int'(bus_rdata), 0);

    // R1 send through the data address; upper write bits ignored
    bus_write(A_DATA, 16'h1AA5);
    repeat (3) @(negedge clk);
    expect_reg(A_STAT, 16'h0002, "R4");
    poll_tx_idle();

    // R1 through the status address, R2 a second write while busy is dropped
    bus_write(A_STAT, 16'h003C);
    repeat (100) @(negedge clk);
    bus_write(A_DATA, 16'h00FF);
    expect_reg(A_STAT, 16'h0002, "R2");
    poll_tx_idle();

    // R3 write to an unmapped address
    bus_write(12'h7FF, 16'h0055);
    repeat (20) @(negedge clk);
    expect_reg(A_STAT, 16'h0006, "R3");
    check(ser_txd === 1'b1, "R3", "txd", int'(ser_txd), 1);

    // R11 start plus eight zero bits stay low for nine bit times
    bus_write(A_DATA, 16'h0000);
    n = 0;
    while (ser_txd === 1'b0 && n < 20 * BITC) begin
      n++;
      @(negedge clk);
    end
    check(n == 9 * BITC, "R11", "low cycles for 0x00", n, 9 * BITC);
    poll_tx_idle();

    // R5 / R6 receive, read, clear
    send_rx(8'h5A, 1'b1);
    expect_reg(A_STAT, 16'h0007, "R6");
    expect_reg(A_DATA, 16'h005A, "R5");
    expect_reg(A_STAT, 16'h0006, "R6");

    // R6 newer frame overwrites the unread byte
    send_rx(8'hC3, 1'b1);
    send_rx(8'h81, 1'b1);
    expect_reg(A_DATA, 16'h0081, "R6");

    // R7 low stop bit: frame discarded, old byte kept
    send_rx(8'h77, 1'b0);
    repeat (2 * BITC) @(negedge clk);
    expect_reg(A_STAT, 16'h0006, "R7");
    expect_reg(A_DATA, 16'h0081, "R7");

    // R8 quarter-bit glitch rejected
    ser_rxd = 1'b0;
    repeat (BITC / 4) @(negedge clk);
    ser_rxd = 1'b1;
    repeat (2 * BITC) @(negedge clk);
    expect_reg(A_STAT, 16'h0006, "R8");

    // R9 simultaneous send and receive
    fork
      bus_write(A_DATA, 16'h0096);
      send_rx(8'hE7, 1'b1);
    join
    poll_tx_idle();
    expect_reg(A_STAT, 16'h0007, "R9");
    expect_reg(A_DATA, 16'h00E7, "R9");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule